// File: doc/BRIEF.md
# DMA Channel Peripheral Handshake

This block sits between one peripheral and one DMA channel and runs a four-phase request/acknowledge exchange for each data item. The peripheral holds a level request while it is ready to move one item. The block brings that request into its own clock domain, tells the channel arbiter that the channel has work, and waits. It waits for as long as the arbiter holds off because the bus is busy or other channels rank higher.

When the arbiter signals that the bus command for this channel has gone out, the block records exactly one accepted access. It raises the acknowledge and keeps it high until the synchronized request is seen low. It then spends one closing cycle with the acknowledge low before a fresh request can be taken. While the acknowledge is high, further grants and a request that stays high cannot cause a second access. A request that falls before any grant arrives is dropped without an access.

Top module: `dma_req_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it, `periph_ack`, `arb_pending` and `access_accept` are all 0.
- R2: A request held high is shown on `arb_pending` exactly SYNC_STAGES+1 clock edges after it rises. `arb_pending` stays high until a grant is taken.
- R3: `arb_pending` and `periph_ack` are never high in the same cycle.
- R4: A grant during a cycle with `arb_pending` high gives `access_accept`=1 in that cycle. On the next edge `periph_ack` goes to 1 and `arb_pending` goes to 0.
- R5: A grant while `arb_pending` is 0 has no effect: `access_accept` stays 0 and `periph_ack` stays 0.
- R6: While `periph_ack` is high it stays high as long as the synchronized request is high. Grants in that time give no `access_accept`.
- R7: `periph_ack` falls exactly SYNC_STAGES+1 clock edges after the request falls.
- R8: After `periph_ack` falls, a request raised in that same cycle is treated as new. It is shown on `arb_pending` SYNC_STAGES+1 edges later, and each complete handshake produces exactly one `access_accept`.
- R9: If the request falls while pending with no grant, `arb_pending` drops SYNC_STAGES+1 edges later with no `access_accept` and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| periph_req | input | 1 | Level request from the peripheral |
| arb_grant | input | 1 | Arbiter: bus command for this channel issued this cycle |
| periph_ack | output | 1 | Acknowledge to the peripheral |
| arb_pending | output | 1 | Channel has a request waiting for arbitration |
| access_accept | output | 1 | One-cycle pulse: a bus access was taken for this request |

## Verification
The hardest case to reach is a grant that arrives while the acknowledge is already high and the request has not yet fallen. Only that case can produce a duplicate access. The stimulus holds the grant high for several cycles straight after the acknowledge rises and counts accept pulses. A second hard case is a request raised in the very cycle the acknowledge falls. The bench drives it on the cycle it first samples the acknowledge low, and checks that the new request gets its own single access.

// File: rtl/hsk_pkg.sv
// Package: shared types for the DMA peripheral handshake.
// Assumes: none.
package hsk_pkg;
    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_PENDING  = 2'd1,
        HS_ACK_HIGH = 2'd2,
        HS_WAIT_LOW = 2'd3
    } hsk_state_e;
endpackage

// File: rtl/hsk_req_sync.sv
// Module: request synchronizer.
// Moves the peripheral request level into the channel clock domain through
// STAGES flops. STAGES = 0 gives a direct connection, for a peripheral that
// already runs on the same clock.
// Assumes: the request is a level held for longer than STAGES cycles.
module hsk_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign req_out = req_in;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            // Shift the request through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q[0] <= req_in;
                    for (int i = 1; i < STAGES; i++) begin
                        q[i] <= q[i-1];
                    end
                end
            end
            assign req_out = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hsk_fsm.sv
// Module: four-phase handshake controller.
// Marks a synchronized request as pending and takes exactly one grant for it.
// It then holds the acknowledge until the request falls, and closes with one
// cycle of acknowledge low.
// Assumes: req_s is already synchronous to clk.
module hsk_fsm
    import hsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic grant,
    output logic ack,
    output logic pending,
    output logic accept
);
    hsk_state_e state_q, state_d;

    // Next-state selection for the handshake phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE:     if (req_s) state_d = HS_PENDING;
            HS_PENDING: begin
                if (grant)       state_d = HS_ACK_HIGH;
                else if (!req_s) state_d = HS_IDLE;
            end
            HS_ACK_HIGH: if (!req_s) state_d = HS_WAIT_LOW;
            HS_WAIT_LOW: state_d = HS_IDLE;
            default:     state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    assign pending = (state_q == HS_PENDING);
    assign ack     = (state_q == HS_ACK_HIGH);
    assign accept  = pending && grant;
endmodule

// File: rtl/dma_req_handshake.sv
// Module: top of the DMA channel peripheral handshake.
// Synchronizes the peripheral request and runs the four-phase exchange
// against the channel arbiter grant.
// Assumes: arb_grant is high only in cycles when the arbiter has issued this
// channel's bus command.
module dma_req_handshake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic periph_req,
    input  logic arb_grant,
    output logic periph_ack,
    output logic arb_pending,
    output logic access_accept
);
    logic req_sync;

    hsk_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (periph_req),
        .req_out (req_sync)
    );

    hsk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_sync),
        .grant   (arb_grant),
        .ack     (periph_ack),
        .pending (arb_pending),
        .accept  (access_accept)
    );
endmodule

// File: rtl/dma_req_handshake_chk.sv
// Module: protocol checker bound to dma_req_handshake.
// Assumes: req_sync is the synchronized request inside the top.
module dma_req_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic req_sync,
    input logic arb_grant,
    input logic periph_ack,
    input logic arb_pending,
    input logic access_accept
);
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_pending && periph_ack));

    p_accept_when_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access_accept |-> arb_pending);

    p_ack_follows_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        access_accept |=> periph_ack);

    p_ack_needs_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_ack) |-> $past(access_accept));

    p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && req_sync) |=> periph_ack);

    p_no_second_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> !access_accept);

    p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pending && req_sync && !arb_grant) |=> arb_pending);
endmodule

bind dma_req_handshake dma_req_handshake_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_sync      (req_sync),
    .arb_grant     (arb_grant),
    .periph_ack    (periph_ack),
    .arb_pending   (arb_pending),
    .access_accept (access_accept)
);

// File: tb/dma_req_handshake_bench.sv
module dma_req_handshake_bench;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic periph_req = 1'b0;
    logic arb_grant = 1'b0;
    logic periph_ack, arb_pending, access_accept;

    int n_checks = 0;
    int n_fail = 0;
    int n_accepts = 0;
    int n_overlap = 0;

    dma_req_handshake #(.SYNC_STAGES(SYNC)) u_dma_req_handshake (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .arb_grant(arb_grant),
        .periph_ack(periph_ack), .arb_pending(arb_pending), .access_accept(access_accept)
    );

    always #5 clk = ~clk;

    // Monitor: sample 1 ns before each rising edge.
    always begin
        @(negedge clk);
        #4;
        if (rst_n && access_accept) n_accepts++;
        if (rst_n && periph_ack && arb_pending) n_overlap++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: outputs quiet during and just after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk(!periph_ack && !arb_pending && !access_accept, "R1 in reset",
            {periph_ack, arb_pending, access_accept}, 0);
        rst_n = 1'b1;
        step(1);
        chk(!periph_ack && !arb_pending && !access_accept, "R1 after reset",
            {periph_ack, arb_pending, access_accept}, 0);
    endtask

    // Raise request and check the exact pending latency (R2).
    task automatic raise_and_wait_pending(input string tag);
        periph_req = 1'b1;
        step(LAT - 1);
        chk(arb_pending == 1'b0, {tag, " early"}, arb_pending, 0);
        step(1);
        chk(arb_pending == 1'b1, {tag, " on time"}, arb_pending, 1);
    endtask

    // One-cycle grant while pending (R4).
    task automatic grant_once();
        arb_grant = 1'b1;
        #1;
        chk(access_accept == 1'b1, "R4 accept pulse", access_accept, 1);
        step(1);
        arb_grant = 1'b0;
        chk(periph_ack && !arb_pending, "R4 ack up pending down",
            {periph_ack, arb_pending}, 2);
    endtask

    // Drop request and check exact acknowledge release (R7).
    task automatic drop_and_wait_ack_low();
        periph_req = 1'b0;
        step(LAT - 1);
        chk(periph_ack == 1'b1, "R7 ack held", periph_ack, 1);
        step(1);
        chk(periph_ack == 1'b0, "R7 ack released", periph_ack, 0);
    endtask

    task automatic t_single();
        int base;
        base = n_accepts;
        raise_and_wait_pending("R2");
        step(3);
        chk(arb_pending == 1'b1, "R2 pending held", arb_pending, 1);
        grant_once();
        step(2);
        chk(periph_ack == 1'b1, "R6 ack held with request", periph_ack, 1);
        drop_and_wait_ack_low();
        step(2);
        chk(n_accepts - base == 1, "R8 one access", n_accepts - base, 1);
    endtask

    task automatic t_grant_idle();
        int base;
        base = n_accepts;
        arb_grant = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(!access_accept && !periph_ack, "R5 idle grant",
                {access_accept, periph_ack}, 0);
            step(1);
        end
        arb_grant = 1'b0;
        chk(n_accepts == base, "R5 no accept", n_accepts - base, 0);
    endtask

    task automatic t_extra_grants();
        int base;
        base = n_accepts;
        raise_and_wait_pending("R2 second");
        grant_once();
        arb_grant = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(!access_accept && periph_ack, "R6 extra grant",
                {access_accept, periph_ack}, 1);
            step(1);
        end
        arb_grant = 1'b0;
        drop_and_wait_ack_low();
        step(2);
        chk(n_accepts - base == 1, "R6 single access", n_accepts - base, 1);
    endtask

    task automatic t_back_to_back();
        int base;
        base = n_accepts;
        raise_and_wait_pending("R2 b2b first");
        grant_once();
        drop_and_wait_ack_low();
        raise_and_wait_pending("R8 fresh request");
        grant_once();
        drop_and_wait_ack_low();
        step(2);
        chk(n_accepts - base == 2, "R8 two accesses", n_accepts - base, 2);
    endtask

    task automatic t_withdraw();
        int base;
        base = n_accepts;
        raise_and_wait_pending("R2 withdraw");
        periph_req = 1'b0;
        step(LAT - 1);
        chk(arb_pending == 1'b1, "R9 still pending", arb_pending, 1);
        step(1);
        chk(!arb_pending && !periph_ack, "R9 dropped",
            {arb_pending, periph_ack}, 0);
        step(2);
        chk(n_accepts == base, "R9 no access", n_accepts - base, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        step(2);
        t_single();
        t_grant_idle();
        t_extra_grants();
        t_back_to_back();
        t_withdraw();
        chk(n_overlap == 0, "R3 pending with ack", n_overlap, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule